// File: doc/BRIEF.md
# Gated Square-Wave Tap Selector

This block drives one square-wave output from a free-running binary divider chain. A 4-bit rate code in one control register picks which of thirteen divider taps reaches the output. An enable bit in a second control register turns the output on or off. A power-fail input forces the output low at once.

Both registers sit behind a small address/data/write-enable port and read back combinationally. A new rate code or enable value does not reach the pin straight away. It waits until the output is low. The output then stays low until the newly selected tap starts a fresh high phase. As a result, no shortened high pulse ever appears on the pin when software reprograms the block, and none appears when power returns.

Divider bit `TAP_LSB + k` feeds tap `k`. With the default `TAP_LSB = 0`, rate code `c` gives a period of `2^c` clock cycles.

Top module: `sqw_tap_gen`

## Requirements
- R1: After reset, both control registers read 0 and `sqw_o` is low.
- R2: A write with `addr_i = 0` stores `wdata_i[3:0]` as the rate code. A read at address 0 returns the code in bits 3:0, and bits 7:4 read 0.
- R3: A write with `addr_i = 1` stores `wdata_i[3]` as the enable bit. A read at address 1 returns it in bit 3, and all other bits read 0.
- R4: While the adopted rate code is 0 or the adopted enable bit is 0, `sqw_o` stays low.
- R5: With the enable bit set and rate code `c` in 1..13, `sqw_o` has a period of `2^(c+TAP_LSB)` cycles and equal high and low times.
- R6: Rate codes 14 and 15 produce the same waveform as code 13.
- R7: A new rate code or enable value is adopted only in a cycle where the output is low. A high phase already in progress finishes at its full length.
- R8: After a new setting is adopted, `sqw_o` stays low until the selected tap rises. The first high pulse is therefore a full half period.
- R9: While `pf_i` is high, `sqw_o` is low in the same cycle. After `pf_i` falls, the output resumes only at the next rise of the tap, with a full-length high pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; also drives the divider chain |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 1 | Register select: 0 = rate, 1 = control |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write enable, sampled on the rising clock edge |
| rdata_o | output | 8 | Read data for the register at `addr_i` |
| pf_i | input | 1 | Power-fail indication, active high |
| sqw_o | output | 1 | Gated square-wave output |

## Verification
The hardest case to reach is a reconfiguration that arrives in the middle of a high phase. The old pulse must run to its full length, and the first pulse at the new rate must also be full length. The bench sets a slow rate and waits for a rising edge of `sqw_o`. A few cycles into that high phase, it writes a fast rate in a concurrent branch while another branch counts the high time. The bench then checks both the stretched old pulse and the first new pulse. Power-fail is asserted mid-pulse in the same way, and its release is followed by a measurement of the first pulse.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
  localparam int RATE_W    = 4;
  localparam int DATA_W    = 8;
  localparam int NUM_TAPS  = 13;
  localparam int TAP_IDX_W = $clog2(NUM_TAPS);
  localparam int EN_BIT    = 3;

  localparam logic ADDR_RATE = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

  // code 0 is "off"; codes above NUM_TAPS clamp to the slowest tap
  function automatic logic [TAP_IDX_W-1:0] rate_to_tap(input logic [RATE_W-1:0] code);
    logic [TAP_IDX_W-1:0] idx;
    if (code == '0)
      idx = '0;
    else if (int'(code) > NUM_TAPS)
      idx = TAP_IDX_W'(NUM_TAPS - 1);
    else
      idx = TAP_IDX_W'(code - 1'b1);
    return idx;
  endfunction
endpackage

// File: rtl/sqw_regs.sv
module sqw_regs
  import sqw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [RATE_W-1:0] rate_o,
  output logic              en_o
);
  logic [RATE_W-1:0] rate_q;
  logic              en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= '0;
      en_q   <= 1'b0;
    end else if (we_i) begin
      if (addr_i == ADDR_RATE) rate_q <= wdata_i[RATE_W-1:0];
      else                     en_q   <= wdata_i[EN_BIT];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_RATE) rdata_o[RATE_W-1:0] = rate_q;
    else                     rdata_o[EN_BIT]     = en_q;
  end

  assign rate_o = rate_q;
  assign en_o   = en_q;
endmodule

// File: rtl/sqw_divider.sv
module sqw_divider #(
  parameter int TAP_LSB  = 0,
  parameter int NUM_TAPS = 13,
  localparam int CNT_W   = TAP_LSB + NUM_TAPS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic [NUM_TAPS-1:0] lvl_o,
  output logic [NUM_TAPS-1:0] rise_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  // bit b has just risen when the low b+1 bits read 100..0
  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    localparam int B = TAP_LSB + k;
    assign lvl_o[k] = cnt_q[B];
    if (B == 0) begin : g_lsb
      assign rise_o[k] = cnt_q[0];
    end else begin : g_upper
      assign rise_o[k] = cnt_q[B] & ~(|cnt_q[B-1:0]);
    end
  end
endmodule

// File: rtl/sqw_tap_mux.sv
module sqw_tap_mux
  import sqw_pkg::*;
(
  input  logic [RATE_W-1:0]   code_i,
  input  logic [NUM_TAPS-1:0] lvl_i,
  input  logic [NUM_TAPS-1:0] rise_i,
  output logic                lvl_o,
  output logic                rise_o
);
  logic [TAP_IDX_W-1:0] idx;

  assign idx = rate_to_tap(code_i);

  always_comb begin
    lvl_o  = 1'b0;
    rise_o = 1'b0;
    for (int k = 0; k < NUM_TAPS; k++) begin
      if (idx == TAP_IDX_W'(k)) begin
        lvl_o  = lvl_i[k];
        rise_o = rise_i[k];
      end
    end
  end
endmodule

// File: rtl/sqw_gate.sv
module sqw_gate
  import sqw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              en_i,
  input  logic              pf_i,
  input  logic              lvl_i,
  input  logic              rise_i,
  output logic [RATE_W-1:0] act_code_o,
  output logic              act_en_o,
  output logic              raw_o,
  output logic              sqw_o
);
  logic [RATE_W-1:0] act_code_q;
  logic              act_en_q;
  logic              armed_q;
  logic              out_q;
  logic              act_on;
  logic              cfg_diff;
  logic              adopt;

  assign act_on   = act_en_q && (act_code_q != '0);
  assign cfg_diff = (rate_i != act_code_q) || (en_i != act_en_q);
  assign adopt    = cfg_diff && !out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_code_q <= '0;
      act_en_q   <= 1'b0;
      armed_q    <= 1'b1;
      out_q      <= 1'b0;
    end else begin
      if (adopt) begin
        act_code_q <= rate_i;
        act_en_q   <= en_i;
      end
      if (pf_i || adopt || !act_on) begin
        out_q   <= 1'b0;
        armed_q <= 1'b1;
      end else if (armed_q) begin
        // hold low until the tap starts a fresh high phase
        if (rise_i) begin
          armed_q <= 1'b0;
          out_q   <= 1'b1;
        end
      end else begin
        out_q <= lvl_i;
      end
    end
  end

  assign act_code_o = act_code_q;
  assign act_en_o   = act_en_q;
  assign raw_o      = out_q;
  assign sqw_o      = out_q & ~pf_i;
endmodule

// File: rtl/sqw_tap_gen.sv
module sqw_tap_gen
  import sqw_pkg::*;
#(
  parameter int TAP_LSB = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              pf_i,
  output logic              sqw_o
);
  logic [RATE_W-1:0]   rate_q;
  logic                en_q;
  logic [RATE_W-1:0]   act_code;
  logic                act_en;
  logic                sqw_raw;
  logic [NUM_TAPS-1:0] tap_lvl;
  logic [NUM_TAPS-1:0] tap_rise;
  logic                sel_lvl;
  logic                sel_rise;

  sqw_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .we_i    (we_i),
    .rdata_o (rdata_o),
    .rate_o  (rate_q),
    .en_o    (en_q)
  );

  sqw_divider #(
    .TAP_LSB  (TAP_LSB),
    .NUM_TAPS (NUM_TAPS)
  ) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_o  (tap_lvl),
    .rise_o (tap_rise)
  );

  sqw_tap_mux u_mux (
    .code_i (act_code),
    .lvl_i  (tap_lvl),
    .rise_i (tap_rise),
    .lvl_o  (sel_lvl),
    .rise_o (sel_rise)
  );

  sqw_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rate_i     (rate_q),
    .en_i       (en_q),
    .pf_i       (pf_i),
    .lvl_i      (sel_lvl),
    .rise_i     (sel_rise),
    .act_code_o (act_code),
    .act_en_o   (act_en),
    .raw_o      (sqw_raw),
    .sqw_o      (sqw_o)
  );
endmodule

// File: rtl/sqw_tap_gen_chk.sv
module sqw_tap_gen_chk
  import sqw_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              we_i,
  input logic              pf_i,
  input logic              sqw_o,
  input logic [RATE_W-1:0] rate_q,
  input logic              en_q,
  input logic [RATE_W-1:0] act_code,
  input logic              act_en,
  input logic              sqw_raw
);
  // R9
  pf_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_i |-> !sqw_o);

  // R4
  off_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_en || act_code == '0) |-> !sqw_o);

  // R7
  adopt_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_code != $past(act_code) || act_en != $past(act_en)) |-> !$past(sqw_raw));

  // R2
  rate_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_RATE) |=> rate_q == $past(wdata_i[RATE_W-1:0]));

  // R3
  en_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_CTRL) |=> en_q == $past(wdata_i[EN_BIT]));
endmodule

bind sqw_tap_gen sqw_tap_gen_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .we_i     (we_i),
  .pf_i     (pf_i),
  .sqw_o    (sqw_o),
  .rate_q   (rate_q),
  .en_q     (en_q),
  .act_code (act_code),
  .act_en   (act_en),
  .sqw_raw  (sqw_raw)
);

// File: tb/sqw_tap_gen_tb.sv
module sqw_tap_gen_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       addr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       we_i = 1'b0;
  logic [7:0] rdata_o;
  logic       pf_i = 1'b0;
  logic       sqw_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  sqw_tap_gen u_dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .we_i    (we_i),
    .rdata_o (rdata_o),
    .pf_i    (pf_i),
    .sqw_o   (sqw_o)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(logic a, output int v);
    addr_i = a;
    #1 v = int'(rdata_o);
  endtask

  // returns at the first negedge where sqw_o is seen high after a low
  task automatic wait_rise(output bit ok);
    logic prev = sqw_o;
    ok = 0;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk_i);
      if (!prev && sqw_o) begin ok = 1; break; end
      prev = sqw_o;
    end
  endtask

  task automatic count_high(output int n);
    n = 0;
    while (sqw_o && n < 40000) begin n++; @(negedge clk_i); end
  endtask

  task automatic count_low(output int n);
    n = 0;
    while (!sqw_o && n < 40000) begin n++; @(negedge clk_i); end
  endtask

  task automatic t_reset();
    int v;
    rd(1'b0, v); check("R1 rate reg", v, 0);
    rd(1'b1, v); check("R1 ctrl reg", v, 0);
    check("R1 sqw low", int'(sqw_o), 0);
  endtask

  task automatic t_regs();
    int v;
    wr(1'b0, 8'hFA); rd(1'b0, v); check("R2 rate readback", v, 8'h0A);
    wr(1'b1, 8'hFF); rd(1'b1, v); check("R3 ctrl readback", v, 8'h08);
    wr(1'b1, 8'hF7); rd(1'b1, v); check("R3 ctrl cleared", v, 0);
    wr(1'b0, 8'h00); rd(1'b0, v); check("R2 rate cleared", v, 0);
  endtask

  task automatic t_off();
    int hi = 0;
    wr(1'b0, 8'h03);
    repeat (100) begin @(negedge clk_i); hi += int'(sqw_o); end
    check("R4 enable clear keeps low", hi, 0);
    wr(1'b0, 8'h00); wr(1'b1, 8'h08);
    hi = 0;
    repeat (100) begin @(negedge clk_i); hi += int'(sqw_o); end
    check("R4 code zero keeps low", hi, 0);
  endtask

  task automatic t_periods();
    bit ok; int hi; int lo; int half;
    for (int c = 1; c <= 15; c++) begin
      wr(1'b0, 8'(c));
      half = (c > 13) ? 4096 : (1 << (c - 1));
      wait_rise(ok);
      check(c > 13 ? "R6 start" : "R5 start", int'(ok), 1);
      count_high(hi); count_low(lo);
      check(c > 13 ? "R6 high time" : "R8 first high time", hi, half);
      check(c > 13 ? "R6 low time" : "R5 low time", lo, half);
    end
  endtask

  task automatic t_mid_high();
    bit ok; int hi; int lo;
    wr(1'b0, 8'h05);
    wait_rise(ok); count_high(hi); count_low(lo);
    wait_rise(ok);
    fork
      begin repeat (3) @(negedge clk_i); wr(1'b0, 8'h01); end
      count_high(hi);
    join
    check("R7 old high completes", hi, 16);
    count_low(lo);
    count_high(hi);
    check("R8 first new high", hi, 1);
    count_low(lo);
    check("R5 code 1 low", lo, 1);
  endtask

  task automatic t_disable_running();
    int hi = 0; bit ok; int h; int l;
    wr(1'b0, 8'h04);
    wait_rise(ok); count_high(h); count_low(l);
    wr(1'b1, 8'h00);
    repeat (40) @(negedge clk_i);
    repeat (100) begin @(negedge clk_i); hi += int'(sqw_o); end
    check("R4 disable while running", hi, 0);
    wr(1'b1, 8'h08);
  endtask

  task automatic t_pf();
    bit ok; int hi = 0; int h;
    wr(1'b0, 8'h03);
    wait_rise(ok);
    @(negedge clk_i);
    pf_i = 1'b1;
    #1 check("R9 immediate low", int'(sqw_o), 0);
    repeat (30) begin @(negedge clk_i); hi += int'(sqw_o); end
    check("R9 low during pf", hi, 0);
    @(negedge clk_i); pf_i = 1'b0;
    wait_rise(ok);
    count_high(h);
    check("R9 first high after pf", h, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_regs();
    t_off();
    t_periods();
    t_mid_high();
    t_disable_running();
    t_pf();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 190000 && !done; i++) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule